// File: doc/BRIEF.md
# Flash Status Register with Read Latch

This block keeps the 8-bit status byte of a flash controller. Single-cycle event pulses arrive from the command sequencer and the program/erase engine: program start, erase start, operation done, suspend request, engine paused, resume, the four failure kinds, and clear. From these the block tracks whether the engine is busy, waiting to pause or paused. It also keeps four sticky error flags. Nothing here generates the events.

The byte on the read bus is not live. A snapshot of the current status is taken when a falling edge is seen on either the chip-enable strobe or the output-enable strobe (both active low, sampled on the clock). The snapshot then stays frozen until the next such falling edge. Software must toggle a strobe to see a newer value. The error bits stay set across later commands until an explicit clear or a hardware reset. A stale error therefore makes the next operation look failed unless software clears it first.

Top module: `flash_status_reg`

## Requirements
- R1: Reset (rst_n low, asynchronous) makes the read bus show 80h.
- R2: Bit 7 reads 0 while a program or erase is running and 1 when the engine is idle.
- R3: After a suspend request, bit 7 stays 0 until the engine-paused event; it then reads 1.
- R4: An erase that pauses sets bit 6 and leaves bit 2 at 0; a resume clears bit 6 and bit 7 returns to 0. Bits 6 and 2 are never 1 together.
- R5: A program that pauses sets bit 2; a resume clears it.
- R6: If the done event arrives after a suspend request but before the paused event, no suspend bit is set and bit 7 reads 1.
- R7: The failure events set these bits: erase failure sets bit 5, program failure sets bit 4, bad supply at start sets bit 3, locked-block access sets bit 1.
- R8: Bits 5, 4, 3 and 1 stay set through later start and done events. Only the clear event resets them, to 0.
- R9: When the clear event and a failure event arrive in the same cycle, the failing bit ends up 1 and the other error bits end up 0.
- R10: Bit 0 always reads 0.
- R11: The read bus changes only one clock after a falling edge of ce_n or oe_n. It then shows the status as it stood just before that edge. With no falling edge, the bus holds its value even when the status changes.
- R12: A hardware reset in the middle of an operation with errors set returns the bus to 80h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| evt_start_prog | input | 1 | Program operation started (pulse) |
| evt_start_erase | input | 1 | Erase operation started (pulse) |
| evt_done | input | 1 | Engine finished the operation (pulse) |
| evt_susp_req | input | 1 | Suspend requested (pulse) |
| evt_paused | input | 1 | Engine has actually paused (pulse) |
| evt_resume | input | 1 | Suspended operation resumed (pulse) |
| evt_fail_erase | input | 1 | Erase failure (pulse) |
| evt_fail_prog | input | 1 | Program failure (pulse) |
| evt_vpp_bad | input | 1 | Program supply invalid at start (pulse) |
| evt_lock_err | input | 1 | Attempt to modify a locked block (pulse) |
| evt_clear | input | 1 | Clear-status command (pulse) |
| ce_n | input | 1 | Chip-enable strobe, active low |
| oe_n | input | 1 | Output-enable strobe, active low |
| rd_data | output | 8 | Latched status byte |

## Verification
The bench targets the gap between a suspend request and the actual pause. A design that raised ready on the request would show C0h/84h too early. A design that let a late done leave a suspend bit behind would show 84h instead of 80h. It checks stickiness by starting and finishing a new program while errors are set. A design that cleared errors on start would read 00h/80h there instead of 3Ah/BAh. A clear that shares a cycle with a program failure must leave 90h, not 80h. Finally, the bench changes the status with no strobe movement and expects the old byte to stay on the bus. It then moves only ce_n and expects the new byte. A design that read live, or that watched only oe_n, would fail one of these two checks.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  localparam int STAT_W  = 8;
  localparam int N_ERR   = 4;
  localparam logic [STAT_W-1:0] STAT_RESET = 8'h80;

  // error vector order: [3] erase fail, [2] program fail, [1] supply bad, [0] lock hit
  localparam int ERR_ERASE = 3;
  localparam int ERR_PROG  = 2;
  localparam int ERR_VPP   = 1;
  localparam int ERR_LOCK  = 0;

  typedef enum logic [2:0] {
    ENG_IDLE,
    ENG_PROG_RUN,
    ENG_ERASE_RUN,
    ENG_PROG_PEND,
    ENG_ERASE_PEND,
    ENG_PROG_HALT,
    ENG_ERASE_HALT
  } eng_state_t;

  function automatic logic eng_is_ready(eng_state_t s);
    return (s == ENG_IDLE) || (s == ENG_PROG_HALT) || (s == ENG_ERASE_HALT);
  endfunction

  function automatic logic eng_is_pending(eng_state_t s);
    return (s == ENG_PROG_PEND) || (s == ENG_ERASE_PEND);
  endfunction

  function automatic logic [STAT_W-1:0] pack_status(
    input logic ready,
    input logic erase_halt,
    input logic prog_halt,
    input logic [N_ERR-1:0] err
  );
    logic [STAT_W-1:0] b;
    b    = '0;
    b[7] = ready;
    b[6] = erase_halt;
    b[5] = err[ERR_ERASE];
    b[4] = err[ERR_PROG];
    b[3] = err[ERR_VPP];
    b[2] = prog_halt;
    b[1] = err[ERR_LOCK];
    b[0] = 1'b0;
    return b;
  endfunction

  function automatic logic [N_ERR-1:0] next_flags(
    input logic [N_ERR-1:0] cur,
    input logic [N_ERR-1:0] set_vec,
    input logic             clr
  );
    return (clr ? '0 : cur) | set_vec;
  endfunction
endpackage

// File: rtl/fsr_engine_track.sv
module fsr_engine_track
  import fsr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_prog,
  input  logic start_erase,
  input  logic done,
  input  logic susp_req,
  input  logic paused,
  input  logic resume,
  output logic ready,
  output logic erase_halt,
  output logic prog_halt,
  output logic susp_pending
);
  eng_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ENG_IDLE: begin
        if (start_prog)       state_d = ENG_PROG_RUN;
        else if (start_erase) state_d = ENG_ERASE_RUN;
      end
      ENG_PROG_RUN: begin
        if (done)          state_d = ENG_IDLE;
        else if (susp_req) state_d = ENG_PROG_PEND;
      end
      ENG_ERASE_RUN: begin
        if (done)          state_d = ENG_IDLE;
        else if (susp_req) state_d = ENG_ERASE_PEND;
      end
      ENG_PROG_PEND: begin
        if (done)        state_d = ENG_IDLE;
        else if (paused) state_d = ENG_PROG_HALT;
      end
      ENG_ERASE_PEND: begin
        if (done)        state_d = ENG_IDLE;
        else if (paused) state_d = ENG_ERASE_HALT;
      end
      ENG_PROG_HALT: begin
        if (resume) state_d = ENG_PROG_RUN;
      end
      ENG_ERASE_HALT: begin
        if (resume) state_d = ENG_ERASE_RUN;
      end
      default: state_d = ENG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ENG_IDLE;
    else        state_q <= state_d;
  end

  assign ready        = eng_is_ready(state_q);
  assign susp_pending = eng_is_pending(state_q);
  assign erase_halt   = (state_q == ENG_ERASE_HALT);
  assign prog_halt    = (state_q == ENG_PROG_HALT);
endmodule

// File: rtl/fsr_err_flags.sv
module fsr_err_flags #(
  parameter int N_FLAGS = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_FLAGS-1:0] set_vec,
  input  logic               clr,
  output logic [N_FLAGS-1:0] flags
);
  for (genvar i = 0; i < N_FLAGS; i++) begin : g_flag
    logic q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          q <= 1'b0;
      else if (set_vec[i]) q <= 1'b1;
      else if (clr)        q <= 1'b0;
    end
    assign flags[i] = q;
  end
endmodule

// File: rtl/fsr_read_latch.sv
module fsr_read_latch #(
  parameter int                 W         = 8,
  parameter logic [W-1:0]       RESET_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ce_n,
  input  logic         oe_n,
  input  logic [W-1:0] live,
  output logic [W-1:0] snap,
  output logic         strobe_fall
);
  logic ce_prev, oe_prev;
  logic [W-1:0] snap_q;

  assign strobe_fall = (ce_prev & ~ce_n) | (oe_prev & ~oe_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_prev <= 1'b1;
      oe_prev <= 1'b1;
      snap_q  <= RESET_VAL;
    end else begin
      ce_prev <= ce_n;
      oe_prev <= oe_n;
      if (strobe_fall) snap_q <= live;
    end
  end

  assign snap = snap_q;
endmodule

// File: rtl/flash_status_reg.sv
module flash_status_reg
  import fsr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_start_prog,
  input  logic              evt_start_erase,
  input  logic              evt_done,
  input  logic              evt_susp_req,
  input  logic              evt_paused,
  input  logic              evt_resume,
  input  logic              evt_fail_erase,
  input  logic              evt_fail_prog,
  input  logic              evt_vpp_bad,
  input  logic              evt_lock_err,
  input  logic              evt_clear,
  input  logic              ce_n,
  input  logic              oe_n,
  output logic [STAT_W-1:0] rd_data
);
  logic              eng_ready, eng_erase_halt, eng_prog_halt, susp_pending;
  logic [N_ERR-1:0]  err_set, err_flags;
  logic [STAT_W-1:0] live_stat;
  logic              strobe_fall;

  fsr_engine_track i_eng (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_prog   (evt_start_prog),
    .start_erase  (evt_start_erase),
    .done         (evt_done),
    .susp_req     (evt_susp_req),
    .paused       (evt_paused),
    .resume       (evt_resume),
    .ready        (eng_ready),
    .erase_halt   (eng_erase_halt),
    .prog_halt    (eng_prog_halt),
    .susp_pending (susp_pending)
  );

  always_comb begin
    err_set            = '0;
    err_set[ERR_ERASE] = evt_fail_erase;
    err_set[ERR_PROG]  = evt_fail_prog;
    err_set[ERR_VPP]   = evt_vpp_bad;
    err_set[ERR_LOCK]  = evt_lock_err;
  end

  fsr_err_flags #(.N_FLAGS(N_ERR)) i_err (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (err_set),
    .clr     (evt_clear),
    .flags   (err_flags)
  );

  assign live_stat = pack_status(eng_ready, eng_erase_halt, eng_prog_halt, err_flags);

  fsr_read_latch #(.W(STAT_W), .RESET_VAL(STAT_RESET)) i_latch (
    .clk         (clk),
    .rst_n       (rst_n),
    .ce_n        (ce_n),
    .oe_n        (oe_n),
    .live        (live_stat),
    .snap        (rd_data),
    .strobe_fall (strobe_fall)
  );
endmodule

// File: rtl/flash_status_chk.sv
module flash_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       evt_clear,
  input logic       evt_fail_erase,
  input logic       evt_paused,
  input logic       susp_pending,
  input logic       strobe_fall,
  input logic [7:0] live_stat,
  input logic [7:0] rd_data
);
  AST_BIT0_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[0] == 1'b0); // R10
  AST_HOLD_NO_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_fall |=> $stable(rd_data)); // R11
  AST_PEND_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    susp_pending |-> !live_stat[7]); // R3
  AST_PAUSE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (susp_pending && evt_paused) |=> live_stat[7]); // R3
  AST_STICKY_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
    (live_stat[5] && !evt_clear) |=> live_stat[5]); // R8
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    evt_fail_erase |=> live_stat[5]); // R9
  AST_SUSP_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(live_stat[6] && live_stat[2])); // R4
endmodule

bind flash_status_reg flash_status_chk i_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .evt_clear      (evt_clear),
  .evt_fail_erase (evt_fail_erase),
  .evt_paused     (evt_paused),
  .susp_pending   (susp_pending),
  .strobe_fall    (strobe_fall),
  .live_stat      (live_stat),
  .rd_data        (rd_data)
);

// File: tb/test_flash_status_reg.sv
module test_flash_status_reg;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b0;
  logic oe_n = 1'b1;
  logic [10:0] ev = '0;
  logic [7:0] rd_data;

  // event bit positions in ev
  localparam int E_SP = 0, E_SE = 1, E_DN = 2, E_SR = 3, E_PA = 4, E_RS = 5;
  localparam int E_FE = 6, E_FP = 7, E_VB = 8, E_LK = 9, E_CL = 10;

  int checks = 0;
  int failures = 0;
  string cur_req = "R1";
  bit started = 1'b0;

  always #2 clk = ~clk;

  flash_status_reg i_flash_status_reg (
    .clk(clk), .rst_n(rst_n),
    .evt_start_prog(ev[E_SP]), .evt_start_erase(ev[E_SE]), .evt_done(ev[E_DN]),
    .evt_susp_req(ev[E_SR]), .evt_paused(ev[E_PA]), .evt_resume(ev[E_RS]),
    .evt_fail_erase(ev[E_FE]), .evt_fail_prog(ev[E_FP]), .evt_vpp_bad(ev[E_VB]),
    .evt_lock_err(ev[E_LK]), .evt_clear(ev[E_CL]),
    .ce_n(ce_n), .oe_n(oe_n), .rd_data(rd_data)
  );

  // behavioural reference: mode 0 idle, 1 busy, 2 waiting to pause, 3 paused
  int  m_mode = 0;
  bit  m_is_erase = 0;
  bit  m_efail = 0, m_pfail = 0, m_vpp = 0, m_lock = 0;
  bit  m_pce = 1, m_poe = 1;
  int  m_snap = 128;

  function automatic int model_byte();
    int v = 0;
    if (m_mode == 0 || m_mode == 3) v += 128;
    if (m_mode == 3 && m_is_erase)  v += 64;
    if (m_efail) v += 32;
    if (m_pfail) v += 16;
    if (m_vpp)   v += 8;
    if (m_mode == 3 && !m_is_erase) v += 4;
    if (m_lock)  v += 2;
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_is_erase = 0;
      m_efail = 0; m_pfail = 0; m_vpp = 0; m_lock = 0;
      m_pce = 1; m_poe = 1; m_snap = 128;
    end else begin
      if ((m_pce && !ce_n) || (m_poe && !oe_n)) m_snap = model_byte();
      m_pce = ce_n; m_poe = oe_n;
      case (m_mode)
        0: if (ev[E_SP]) begin m_mode = 1; m_is_erase = 0; end
           else if (ev[E_SE]) begin m_mode = 1; m_is_erase = 1; end
        1: if (ev[E_DN]) m_mode = 0; else if (ev[E_SR]) m_mode = 2;
        2: if (ev[E_DN]) m_mode = 0; else if (ev[E_PA]) m_mode = 3;
        3: if (ev[E_RS]) m_mode = 1;
        default: m_mode = 0;
      endcase
      if (ev[E_CL]) begin m_efail = 0; m_pfail = 0; m_vpp = 0; m_lock = 0; end
      if (ev[E_FE]) m_efail = 1;
      if (ev[E_FP]) m_pfail = 1;
      if (ev[E_VB]) m_vpp = 1;
      if (ev[E_LK]) m_lock = 1;
    end
  end

  always @(negedge clk) begin
    if (started) begin
      checks++;
      if (rd_data !== 8'(m_snap)) begin
        failures++;
        $display("FAIL %s model compare: actual %02h expected %02h", cur_req, rd_data, 8'(m_snap));
      end
    end
  end

  task automatic pulse(input logic [10:0] m);
    @(negedge clk); #1 ev = m;
    @(negedge clk); #1 ev = '0;
  endtask

  task automatic expect_bus(input string req, input logic [7:0] exp);
    checks++;
    if (rd_data !== exp) begin
      failures++;
      $display("FAIL %s: actual %02h expected %02h", req, rd_data, exp);
    end
  endtask

  task automatic read_oe(input string req, input logic [7:0] exp);
    cur_req = req;
    @(negedge clk); #1 oe_n = 1'b1;
    @(negedge clk); #1 oe_n = 1'b0;
    @(negedge clk);
    expect_bus(req, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    expect_bus("R1", 8'h80);
    #1 rst_n = 1'b1;
    started = 1'b1;
    read_oe("R1", 8'h80);
    expect_bus("R10", {7'b1000000, 1'b0});
    // R2 busy and idle
    pulse(11'd1 << E_SP);
    read_oe("R2", 8'h00);
    pulse(11'd1 << E_DN);
    read_oe("R2", 8'h80);
    // R3 / R4 erase suspend
    pulse(11'd1 << E_SE);
    pulse(11'd1 << E_SR);
    read_oe("R3", 8'h00);
    pulse(11'd1 << E_PA);
    read_oe("R4", 8'hC0);
    pulse(11'd1 << E_RS);
    read_oe("R4", 8'h00);
    pulse(11'd1 << E_DN);
    read_oe("R2", 8'h80);
    // R5 program suspend
    pulse(11'd1 << E_SP);
    pulse(11'd1 << E_SR);
    pulse(11'd1 << E_PA);
    read_oe("R5", 8'h84);
    pulse(11'd1 << E_RS);
    read_oe("R5", 8'h00);
    // R6 finish before pause
    pulse(11'd1 << E_SR);
    pulse(11'd1 << E_DN);
    read_oe("R6", 8'h80);
    pulse(11'd1 << E_PA);
    read_oe("R6", 8'h80);
    // R7 error kinds
    pulse(11'd1 << E_FE); read_oe("R7", 8'hA0);
    pulse(11'd1 << E_FP); read_oe("R7", 8'hB0);
    pulse(11'd1 << E_VB); read_oe("R7", 8'hB8);
    pulse(11'd1 << E_LK); read_oe("R7", 8'hBA);
    // R8 sticky through a new operation, then clear
    pulse(11'd1 << E_SP); read_oe("R8", 8'h3A);
    pulse(11'd1 << E_DN); read_oe("R8", 8'hBA);
    pulse(11'd1 << E_CL); read_oe("R8", 8'h80);
    // R9 set beats clear in the same cycle
    pulse((11'd1 << E_FE) | (11'd1 << E_LK));
    read_oe("R9", 8'hA2);
    pulse((11'd1 << E_CL) | (11'd1 << E_FP));
    read_oe("R9", 8'h90);
    // R11 no strobe edge: bus frozen; then a ce_n toggle only
    cur_req = "R11";
    pulse(11'd1 << E_FE);
    repeat (3) @(negedge clk);
    expect_bus("R11", 8'h90);
    #1 ce_n = 1'b1;
    @(negedge clk);
    expect_bus("R11", 8'h90);
    #1 ce_n = 1'b0;
    @(negedge clk);
    expect_bus("R11", 8'hB0);
    // R12 hardware reset mid-operation
    pulse(11'd1 << E_SE);
    read_oe("R12", 8'h30);
    cur_req = "R12";
    @(negedge clk); #1 rst_n = 1'b0;
    @(negedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    expect_bus("R12", 8'h80);
    read_oe("R12", 8'h80);
    expect_bus("R10", 8'h80);
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule